// File: doc/BRIEF.md
# UART Line Status With Per-Character Error Tags

This block keeps the line status word of a UART. Every received character is stored with three tags (parity error, framing error, break), and the tags move through the receive store together with the character. The parity, framing and break bits of the status word therefore describe only the oldest character, the one the CPU reads next. A transmit store holds bytes written by the CPU until the serial transmitter takes them. Its occupancy, together with a shift-busy input from the transmitter, drives the two empty flags. A mode input chooses between a deep store of `DEPTH` entries on each side and a single holding register on each side.

Stream rules. The receiver side has no back-pressure: an incoming character (`rx_valid` high for one cycle) is always taken or dropped, and a drop is reported as overrun. The CPU transmit write is a valid/ready handshake: a byte is accepted on a cycle with `tx_wr_valid` and `tx_wr_ready` both high. `tx_wr_ready` is low when the store is full, and also in a cycle in which the mode input differs from its registered value. The transmitter output is valid/ready as well. A byte leaves on a cycle with `tx_out_valid` and `tx_out_ready` both high. `tx_out_valid` is held at 0 in a mode-change cycle. The status read, the receive-buffer read and the shift-busy signal are plain pins.

Top module: `uart_line_status`

## Requirements
- R1: After reset `lsr_word` reads 0x00000060: bit 6 (transmitter empty) and bit 5 (holding empty) are 1, and every other bit is 0. Bits 31:8 always read 0.
- R2: Bit 0 (data ready) is 1 whenever the receive store holds at least one character. `rbr_data` then shows the oldest stored character. An `rbr_rd` pulse removes that character. Characters come out in arrival order, up to `DEPTH` of them in deep mode (`fifo_en`=1).
- R3: Bit 2 (parity), bit 3 (framing) and bit 4 (break) show the tags of the oldest stored character only. Tags of characters behind it have no effect on these bits. The bits are 0 when the store is empty.
- R4: A status read (`lsr_rd`) clears bits 4:2 for the current oldest character. When a different character becomes the oldest, its tags show afresh. If that happens in the same cycle as a status read, the new character's tags show.
- R5: In deep mode, a character that arrives while the store holds `DEPTH` entries and no read happens in that cycle is discarded. The stored characters stay unchanged and bit 1 (overrun) is set from the next cycle.
- R6: In single mode (`fifo_en`=0) the receive store holds one character. A character that arrives while it is occupied and unread replaces it and sets bit 1.
- R7: Bit 1 stays set until a status read. A new overrun in the same cycle as that read keeps it set.
- R8: Bit 7 (store error) is 0 whenever `fifo_en` is 0. In deep mode it is 1 while any stored character carries a tag. After the last tagged character has left, bit 7 stays 1 until a status read made in or after the cycle in which that character left.
- R9: Bit 5 is 1 when the transmit store is empty. Bit 6 is 1 when the transmit store is empty and `tx_shift_busy` is 0. An accepted write clears both bits from the next cycle.
- R10: `tx_wr_ready` is 1 while the transmit store holds fewer than `DEPTH` bytes (deep mode) or fewer than 1 (single mode). Bytes appear on `tx_out_data` in write order.
- R11: In a cycle where `fifo_en` differs from its value in the previous cycle, both stores are emptied, bit 7 and the read-clear of bits 4:2 are reset, and all receive, read and write inputs of that cycle are ignored. A status read in that cycle still clears bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1 selects deep stores, 0 selects single holding registers |
| rx_valid | input | 1 | A received character is present this cycle |
| rx_data | input | 8 | Received character |
| rx_perr | input | 1 | Parity-error tag of the received character |
| rx_ferr | input | 1 | Framing-error tag of the received character |
| rx_brk | input | 1 | Break tag of the received character |
| rbr_rd | input | 1 | CPU read of the receive buffer; removes the oldest character |
| rbr_data | output | 8 | Oldest stored character |
| lsr_rd | input | 1 | CPU read of the status word |
| lsr_word | output | 32 | Status word, bits 7:0 as in R1 to R9, upper bits 0 |
| tx_wr_valid | input | 1 | CPU write of a byte to transmit |
| tx_wr_data | input | 8 | Byte to transmit |
| tx_wr_ready | output | 1 | Transmit store can accept a byte |
| tx_out_valid | output | 1 | A byte is waiting for the transmitter |
| tx_out_data | output | 8 | Oldest waiting byte |
| tx_out_ready | input | 1 | Transmitter takes the waiting byte |
| tx_shift_busy | input | 1 | Transmit shift register still holds data |

## Verification
The hardest case to reach is a full receive store in which tagged and clean characters are interleaved, with a status read in the same cycle as a head change or an overrun. Only then do R4, R5 and R8 diverge from simpler readings of the rules. The stimulus fills the store to `DEPTH` with a chosen tag pattern and pushes one character too many. It then drains the store while status reads and pops coincide, and a long random phase with frequent mode flips keeps reaching full, single-slot and mid-flush states. A behavioural queue model checks every status bit and data output on every cycle.

// File: rtl/uls_pkg.sv
package uls_pkg;
  localparam int DATA_W = 8;
  localparam int STAT_W = 32;

  typedef struct packed {
    logic              brk;
    logic              ferr;
    logic              perr;
    logic [DATA_W-1:0] data;
  } rx_ent_t;

  function automatic logic tagged_ent(rx_ent_t e);
    return e.brk | e.ferr | e.perr;
  endfunction
endpackage

// File: rtl/uls_rx_store.sv
module uls_rx_store
  import uls_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        deep,
  input  logic                        flush,
  input  logic                        push,
  input  rx_ent_t                     push_ent,
  input  logic                        pop_req,
  input  logic                        stat_rd,
  output logic                        head_vld,
  output logic [DATA_W-1:0]           head_data,
  output logic [2:0]                  tags_live,
  output logic                        overrun_evt,
  output logic [$clog2(DEPTH+1)-1:0]  err_cnt
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] CAP = CW'(DEPTH);
  localparam logic [PW-1:0] LASTP = PW'(DEPTH-1);

  rx_ent_t        mem [DEPTH];
  logic [PW-1:0]  rd_p, wr_p;
  logic [CW-1:0]  cnt, ecnt_nx;
  logic           ack;
  logic           full, do_pop, arrive, room, do_app, do_over, head_chg;
  rx_ent_t        head;

  function automatic logic [PW-1:0] nxt(logic [PW-1:0] p);
    return (p == LASTP) ? '0 : p + 1'b1;
  endfunction

  assign head     = mem[rd_p];
  assign full     = deep ? (cnt == CAP) : (cnt != '0);
  assign do_pop   = pop_req & (cnt != '0) & ~flush;
  assign arrive   = push & ~flush;
  assign room     = ~full | do_pop;
  assign do_app   = arrive & room;
  assign do_over  = arrive & ~room & ~deep;
  assign overrun_evt = arrive & ~room;
  assign head_chg = do_pop | do_over | (do_app & (cnt == '0));

  always_comb begin
    ecnt_nx = err_cnt;
    if ((do_app | do_over) && tagged_ent(push_ent)) ecnt_nx = ecnt_nx + 1'b1;
    if ((do_pop | do_over) && tagged_ent(head))     ecnt_nx = ecnt_nx - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (do_app)       mem[wr_p] <= push_ent;
    else if (do_over) mem[rd_p] <= push_ent;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rd_p    <= '0;
      wr_p    <= '0;
      cnt     <= '0;
      err_cnt <= '0;
      ack     <= 1'b0;
    end else begin
      if (do_pop) rd_p <= nxt(rd_p);
      if (do_app) wr_p <= nxt(wr_p);
      cnt     <= cnt + CW'(do_app) - CW'(do_pop);
      err_cnt <= ecnt_nx;
      if (head_chg)     ack <= 1'b0;
      else if (stat_rd) ack <= 1'b1;
    end
  end

  assign head_vld  = (cnt != '0);
  assign head_data = head.data;
  assign tags_live = {head.brk, head.ferr, head.perr} & {3{head_vld & ~ack}};

  AST_RX_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CAP) else $error("rx count above depth"); // R2
  AST_RX_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (arrive && !room && deep) |=> (cnt == $past(cnt))) else $error("drop changed store"); // R5
  AST_RX_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (!deep && !flush && $past(!deep)) |-> (cnt <= 1)) else $error("single mode over one"); // R6
  AST_RX_ERRCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt <= cnt) else $error("error count above fill"); // R8
endmodule

// File: rtl/uls_tx_store.sv
module uls_tx_store
  import uls_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              deep,
  input  logic              flush,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready,
  output logic              empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] CAP = CW'(DEPTH);
  localparam logic [PW-1:0] LASTP = PW'(DEPTH-1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0]     rd_p, wr_p;
  logic [CW-1:0]     cnt;
  logic              full, do_push, do_pop;

  function automatic logic [PW-1:0] nxt(logic [PW-1:0] p);
    return (p == LASTP) ? '0 : p + 1'b1;
  endfunction

  assign full      = deep ? (cnt == CAP) : (cnt != '0);
  assign wr_ready  = ~full & ~flush;
  assign out_valid = (cnt != '0) & ~flush;
  assign do_push   = wr_valid & wr_ready;
  assign do_pop    = out_valid & out_ready;
  assign out_data  = mem[rd_p];
  assign empty     = (cnt == '0);

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_p] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rd_p <= '0;
      wr_p <= '0;
      cnt  <= '0;
    end else begin
      if (do_pop)  rd_p <= nxt(rd_p);
      if (do_push) wr_p <= nxt(wr_p);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  AST_TX_WR_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    do_push |=> !empty) else $error("accepted write left store empty"); // R9
  AST_TX_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CAP) else $error("tx count above depth"); // R10
endmodule

// File: rtl/uart_line_status.sv
module uart_line_status
  import uls_pkg::*;
#(
  parameter int RX_DEPTH = 16,
  parameter int TX_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_perr,
  input  logic              rx_ferr,
  input  logic              rx_brk,
  input  logic              rbr_rd,
  output logic [DATA_W-1:0] rbr_data,
  input  logic              lsr_rd,
  output logic [STAT_W-1:0] lsr_word,
  input  logic              tx_wr_valid,
  input  logic [DATA_W-1:0] tx_wr_data,
  output logic              tx_wr_ready,
  output logic              tx_out_valid,
  output logic [DATA_W-1:0] tx_out_data,
  input  logic              tx_out_ready,
  input  logic              tx_shift_busy
);
  localparam int ECW = $clog2(RX_DEPTH+1);

  logic           mode_q, flush;
  logic           ovr_q, ferr_hold;
  logic           head_vld, overrun_evt, tx_empty;
  logic [2:0]     tags_live;
  logic [ECW-1:0] err_cnt;
  logic           err_any, store_err;
  rx_ent_t        in_ent;

  assign flush  = fifo_en ^ mode_q;
  assign in_ent = '{brk: rx_brk, ferr: rx_ferr, perr: rx_perr, data: rx_data};

  uls_rx_store #(.DEPTH(RX_DEPTH)) u_rx (
    .clk(clk), .rst_n(rst_n), .deep(fifo_en), .flush(flush),
    .push(rx_valid), .push_ent(in_ent), .pop_req(rbr_rd), .stat_rd(lsr_rd),
    .head_vld(head_vld), .head_data(rbr_data), .tags_live(tags_live),
    .overrun_evt(overrun_evt), .err_cnt(err_cnt)
  );

  uls_tx_store #(.DEPTH(TX_DEPTH)) u_tx (
    .clk(clk), .rst_n(rst_n), .deep(fifo_en), .flush(flush),
    .wr_valid(tx_wr_valid), .wr_data(tx_wr_data), .wr_ready(tx_wr_ready),
    .out_valid(tx_out_valid), .out_data(tx_out_data), .out_ready(tx_out_ready),
    .empty(tx_empty)
  );

  assign err_any = (err_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= 1'b0;
      ovr_q     <= 1'b0;
      ferr_hold <= 1'b0;
    end else begin
      mode_q <= fifo_en;
      if (overrun_evt) ovr_q <= 1'b1;
      else if (lsr_rd) ovr_q <= 1'b0;
      if (flush) ferr_hold <= 1'b0;
      else       ferr_hold <= (err_any | ferr_hold) & ~lsr_rd;
    end
  end

  assign store_err = fifo_en & (err_any | ferr_hold);

  always_comb begin
    lsr_word      = '0;
    lsr_word[7]   = store_err;
    lsr_word[6]   = tx_empty & ~tx_shift_busy;
    lsr_word[5]   = tx_empty;
    lsr_word[4:2] = tags_live;
    lsr_word[1]   = ovr_q;
    lsr_word[0]   = head_vld;
  end

  AST_OVR_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_evt |=> lsr_word[1]) else $error("overrun not flagged"); // R7
  AST_FERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && $past(fifo_en) && !$past(flush) && $past(lsr_word[7]) && !$past(lsr_rd))
      |-> lsr_word[7]) else $error("store error dropped without read"); // R8
  AST_TAGS_NEED_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_word[4:2] != 3'b000) |-> lsr_word[0]) else $error("tags without data"); // R3
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!lsr_word[0] && lsr_word[5])) else $error("mode change left data"); // R11
endmodule

// File: tb/sim_uart_line_status.sv
module sim_uart_line_status;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fifo_en = 1'b0, rx_valid = 1'b0, rx_perr = 1'b0, rx_ferr = 1'b0, rx_brk = 1'b0;
  logic [7:0] rx_data = '0, tx_wr_data = '0;
  logic rbr_rd = 1'b0, lsr_rd = 1'b0, tx_wr_valid = 1'b0, tx_out_ready = 1'b0, tx_shift_busy = 1'b0;
  logic [7:0]  rbr_data, tx_out_data;
  logic [31:0] lsr_word;
  logic tx_wr_ready, tx_out_valid;

  int tests = 0, fails = 0;

  uart_line_status #(.RX_DEPTH(DEPTH), .TX_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk), .rbr_rd(rbr_rd), .rbr_data(rbr_data),
    .lsr_rd(lsr_rd), .lsr_word(lsr_word), .tx_wr_valid(tx_wr_valid), .tx_wr_data(tx_wr_data),
    .tx_wr_ready(tx_wr_ready), .tx_out_valid(tx_out_valid), .tx_out_data(tx_out_data),
    .tx_out_ready(tx_out_ready), .tx_shift_busy(tx_shift_busy)
  );

  always #(PERIOD/2) clk = ~clk;

  // behavioural reference: entry = {brk, ferr, perr, data}
  logic [10:0] rxq[$];
  logic [7:0]  txq[$];
  bit m_fen, m_ack, m_oe, m_hold;

  function automatic int tag_count();
    int n = 0;
    foreach (rxq[i]) if (rxq[i][10:8] != 3'b000) n++;
    return n;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      rxq.delete(); txq.delete();
      m_fen = 0; m_ack = 0; m_oe = 0; m_hold = 0;
    end else if (fifo_en !== m_fen) begin
      rxq.delete(); txq.delete();
      m_ack = 0; m_hold = 0;
      if (lsr_rd) m_oe = 0;
      m_fen = fifo_en;
    end else begin
      int cap, sz, tsz;
      bit pop, room, hchg, tpush, tpop;
      cap  = fifo_en ? DEPTH : 1;
      sz   = rxq.size();
      pop  = rbr_rd && sz > 0;
      room = (sz < cap) || pop;
      hchg = pop || (rx_valid && !room && !fifo_en) || (rx_valid && room && sz == 0);
      m_hold = (tag_count() != 0 || m_hold) && !lsr_rd;
      if (pop) void'(rxq.pop_front());
      if (rx_valid) begin
        if (room) rxq.push_back({rx_brk, rx_ferr, rx_perr, rx_data});
        else if (!fifo_en) rxq[0] = {rx_brk, rx_ferr, rx_perr, rx_data};
      end
      if (hchg) m_ack = 0; else if (lsr_rd) m_ack = 1;
      if (rx_valid && !room) m_oe = 1; else if (lsr_rd) m_oe = 0;
      tsz   = txq.size();
      tpush = tx_wr_valid && tsz < cap;
      tpop  = tx_out_ready && tsz > 0;
      if (tpop) void'(txq.pop_front());
      if (tpush) txq.push_back(tx_wr_data);
      m_fen = fifo_en;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  // compare every cycle, half a period after the edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit dr, fl, tmt;
      int cap;
      logic [2:0] tg;
      dr  = rxq.size() != 0;
      fl  = (fifo_en !== m_fen);
      cap = fifo_en ? DEPTH : 1;
      tg  = (dr && !m_ack) ? rxq[0][10:8] : 3'b000;
      tmt = txq.size() == 0;
      chk("R1 upper bits", {8'h0, lsr_word[31:8]}, 32'h0);
      chk("R2 data ready", {31'h0, lsr_word[0]}, {31'h0, dr});
      if (dr) chk("R2 rbr data", {24'h0, rbr_data}, {24'h0, rxq[0][7:0]});
      chk("R3 R4 head tags", {29'h0, lsr_word[4:2]}, {29'h0, tg});
      chk("R5 R6 R7 overrun", {31'h0, lsr_word[1]}, {31'h0, m_oe});
      chk("R8 store error", {31'h0, lsr_word[7]},
          {31'h0, fifo_en && (tag_count() != 0 || m_hold)});
      chk("R9 holding empty", {31'h0, lsr_word[5]}, {31'h0, tmt});
      chk("R9 tx empty", {31'h0, lsr_word[6]}, {31'h0, tmt && !tx_shift_busy});
      chk("R10 R11 wr ready", {31'h0, tx_wr_ready}, {31'h0, (txq.size() < cap) && !fl});
      chk("R10 R11 out valid", {31'h0, tx_out_valid}, {31'h0, tmt ? 1'b0 : !fl});
      if (!tmt) chk("R10 out data", {24'h0, tx_out_data}, {24'h0, txq[0]});
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
    rx_valid = 0; rbr_rd = 0; lsr_rd = 0; tx_wr_valid = 0;
    rx_perr = 0; rx_ferr = 0; rx_brk = 0;
  endtask

  task automatic send(logic [7:0] d, logic [2:0] t);
    rx_valid = 1; rx_data = d; {rx_brk, rx_ferr, rx_perr} = t;
    cyc();
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 reset word", lsr_word, 32'h0000_0060);
    // deep mode: entering it flushes (R11)
    #1 fifo_en = 1; cyc(); cyc();
    send(8'h11, 3'b000); send(8'h22, 3'b001); send(8'h33, 3'b110);
    @(negedge clk); chk("R3 clean head hides deeper tags", {29'h0, lsr_word[4:2]}, 32'h0);
    chk("R8 tagged entry stored", {31'h0, lsr_word[7]}, 32'h1);
    #1 rbr_rd = 1; cyc();
    @(negedge clk); chk("R3 parity tag at head", {29'h0, lsr_word[4:2]}, 32'h1);
    #1 lsr_rd = 1; cyc();
    @(negedge clk); chk("R4 read clears head tags", {29'h0, lsr_word[4:2]}, 32'h0);
    #1 lsr_rd = 1; rbr_rd = 1; cyc();
    @(negedge clk); chk("R4 new head wins over read", {29'h0, lsr_word[4:2]}, 32'h6);
    #1 rbr_rd = 1; cyc(); rbr_rd = 1; cyc();
    @(negedge clk); chk("R8 sticky after drain", {31'h0, lsr_word[7]}, 32'h1);
    #1 lsr_rd = 1; cyc();
    @(negedge clk); chk("R8 cleared by read", {31'h0, lsr_word[7]}, 32'h0);
    // fill and overrun
    for (int i = 0; i < DEPTH; i++) send(8'(i + 8'h40), (i % 3 == 0) ? 3'b010 : 3'b000);
    send(8'hEE, 3'b100);
    @(negedge clk); chk("R5 overrun set", {31'h0, lsr_word[1]}, 32'h1);
    chk("R5 head kept", {24'h0, rbr_data}, 32'h40);
    #1 lsr_rd = 1; rx_valid = 1; rx_data = 8'hEF; cyc();
    @(negedge clk); chk("R7 new overrun beats read", {31'h0, lsr_word[1]}, 32'h1);
    for (int i = 0; i < DEPTH; i++) begin rbr_rd = 1; lsr_rd = (i == DEPTH - 1); cyc(); end
    // single mode
    #1 fifo_en = 0; cyc();
    send(8'hA1, 3'b000); send(8'hA2, 3'b100);
    @(negedge clk); chk("R6 overwrite data", {24'h0, rbr_data}, 32'hA2);
    chk("R8 off in single mode", {31'h0, lsr_word[7]}, 32'h0);
    // transmit side
    #1 tx_shift_busy = 1; tx_wr_valid = 1; tx_wr_data = 8'h5A; cyc();
    @(negedge clk); chk("R9 write clears holding empty", {31'h0, lsr_word[5]}, 32'h0);
    chk("R10 single slot full", {31'h0, tx_wr_ready}, 32'h0);
    #1 tx_out_ready = 1; cyc(); tx_out_ready = 0; tx_shift_busy = 0; cyc();
    #1 fifo_en = 1; cyc();
    for (int i = 0; i < DEPTH; i++) begin tx_wr_valid = 1; tx_wr_data = 8'(i); cyc(); end
    @(negedge clk); chk("R10 deep store full", {31'h0, tx_wr_ready}, 32'h0);
    #1 tx_out_ready = 1; repeat (DEPTH) cyc(); tx_out_ready = 0;
    // random phase
    for (int n = 0; n < 6000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      rx_valid = r < 45; rx_data = 8'($urandom);
      {rx_brk, rx_ferr, rx_perr} = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b000;
      rbr_rd = $urandom_range(0, 99) < ((n / 500) % 2 ? 20 : 50);
      lsr_rd = $urandom_range(0, 99) < 20;
      tx_wr_valid = $urandom_range(0, 99) < 50; tx_wr_data = 8'($urandom);
      tx_out_ready = $urandom_range(0, 99) < 40;
      tx_shift_busy = $urandom_range(0, 3) == 0;
      if ($urandom_range(0, 199) == 0) fifo_en = ~fifo_en;
      cyc();
    end
    cyc();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule